// File: doc/BRIEF.md
# CAN Fault Confinement Counter Unit

This block holds the transmit and receive error counters of a CAN node and works out the node's fault-confinement state from them. The protocol engine feeds it one-cycle strobes: a receive error, a transmit error, a frame received cleanly, a frame sent cleanly, and a recovery request from software. Each strobe is applied on the next rising clock edge. The counters and the state change on that same edge.

Transmit errors weigh eight times as much as receive errors. A clean frame takes one back off the counter that belongs to it. The state is derived from both counters and selects the polarity of the error flag that the frame logic sends. Once the node reaches bus off it is frozen and drops its enable. It comes back only when a recovery request is made.

Top module: `can_fault_conf`

## Requirements
- R1: A receive-error strobe adds 1 to the receive counter. The counter saturates at 255 and never wraps.
- R2: A transmit-error strobe adds 8 to the transmit counter.
- R3: A clean-frame strobe subtracts 1 from its own counter, and the counter stops at 0. If an error strobe and a clean-frame strobe arrive for the same counter in the same cycle, only the error is applied.
- R4: state_o is 2'd0 (error active) when both counters are 127 or below. It is 2'd1 (error passive) when either counter is above 127 and the transmit counter is 255 or below. It is 2'd2 (bus off) when the transmit counter is above 255. The state updates on the same edge as the counters, so a node that is not in bus off returns to error active as soon as both counters are back at 127 or below.
- R5: flag_recessive_o is 0 in error active, which selects six dominant bits. It is 1 in error passive and in bus off, which selects six recessive bits. node_en_o is 0 only in bus off.
- R6: In bus off, every error and clean-frame strobe is ignored. Both counters and the state hold.
- R7: A recovery request in bus off clears both counters and puts the node in error active on the next edge. A recovery request in any other state has no effect.
- R8: While rst_ni is low, both counters are 0 and the state is error active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_err_i | input | 1 | Receive error detected |
| tx_err_i | input | 1 | Transmit error detected |
| rx_ok_i | input | 1 | Frame received without error |
| tx_ok_i | input | 1 | Frame sent without error |
| recover_i | input | 1 | Software request to leave bus off |
| tec_o | output | 9 | Transmit error counter |
| rec_o | output | 8 | Receive error counter |
| state_o | output | 2 | 0 error active, 1 error passive, 2 bus off |
| flag_recessive_o | output | 1 | Error flag polarity: 1 for recessive, 0 for dominant |
| node_en_o | output | 1 | Node may transmit and receive |

## Verification
On every cycle the assertions check the following:
- each counter's step after a strobe, including receive saturation and the floor at zero;
- the agreement between the state and the counter ranges;
- the freeze in bus off;
- the one-edge result of a recovery request.

Some behaviour shows only in the bench's scenarios, because it depends on the order of many strobes:
- that error wins over a clean frame in the same cycle;
- that an early recovery request is ignored;
- the exact edge on which 126 becomes 134 and the node turns passive;
- the fall back to active at 127;
- the 255 to 263 step into bus off;
- a receive counter that sits at 255 without causing bus off.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
  localparam int unsigned TEC_W       = 9;
  localparam int unsigned REC_W       = 8;
  localparam int unsigned TX_INC      = 8;
  localparam int unsigned RX_INC      = 1;
  localparam int unsigned PASSIVE_LIM = 127;
  localparam int unsigned BUSOFF_LIM  = 255;

  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'd0,
    FC_PASSIVE = 2'd1,
    FC_BUS_OFF = 2'd2
  } fc_state_e;
endpackage

// File: rtl/can_fc_err_cnt.sv
module can_fc_err_cnt #(
  parameter int unsigned W   = 8,
  parameter int unsigned INC = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         err_i,
  input  logic         ok_i,
  input  logic         freeze_i,
  input  logic         clear_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cnt_nxt_o
);
  localparam logic [W:0]   INC_EXT = (W+1)'(INC);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt_q;
  logic [W:0]   sum;

  assign sum = {1'b0, cnt_q} + INC_EXT;

  always_comb begin
    cnt_nxt_o = cnt_q;
    if (clear_i) begin
      cnt_nxt_o = '0;
    end else if (!freeze_i) begin
      if (err_i) begin
        // saturate instead of wrapping
        cnt_nxt_o = sum[W] ? CNT_MAX : sum[W-1:0];
      end else if (ok_i && (cnt_q != '0)) begin
        cnt_nxt_o = cnt_q - W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_nxt_o;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/can_fc_state.sv
module can_fc_state
  import can_fc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TEC_W-1:0] tec_nxt_i,
  input  logic [REC_W-1:0] rec_nxt_i,
  input  logic             recover_i,
  output fc_state_e        state_o,
  output logic             bus_off_o,
  output logic             clear_o
);
  localparam logic [TEC_W-1:0] TEC_PASS = TEC_W'(PASSIVE_LIM);
  localparam logic [TEC_W-1:0] TEC_OFF  = TEC_W'(BUSOFF_LIM);
  localparam logic [REC_W-1:0] REC_PASS = REC_W'(PASSIVE_LIM);

  fc_state_e state_q, state_d;

  assign bus_off_o = (state_q == FC_BUS_OFF);
  assign clear_o   = bus_off_o && recover_i;

  always_comb begin
    state_d = state_q;
    if (bus_off_o) begin
      if (recover_i) state_d = FC_ACTIVE;
    end else if (tec_nxt_i > TEC_OFF) begin
      state_d = FC_BUS_OFF;
    end else if ((tec_nxt_i > TEC_PASS) || (rec_nxt_i > REC_PASS)) begin
      state_d = FC_PASSIVE;
    end else begin
      state_d = FC_ACTIVE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= FC_ACTIVE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf
  import can_fc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_err_i,
  input  logic             tx_err_i,
  input  logic             rx_ok_i,
  input  logic             tx_ok_i,
  input  logic             recover_i,
  output logic [TEC_W-1:0] tec_o,
  output logic [REC_W-1:0] rec_o,
  output logic [1:0]       state_o,
  output logic             flag_recessive_o,
  output logic             node_en_o
);
  logic [TEC_W-1:0] tec_nxt;
  logic [REC_W-1:0] rec_nxt;
  logic             bus_off, clear;
  fc_state_e        state;

  can_fc_err_cnt #(.W(TEC_W), .INC(TX_INC)) u_tec (
    .clk_i(clk_i), .rst_ni(rst_ni), .err_i(tx_err_i), .ok_i(tx_ok_i),
    .freeze_i(bus_off), .clear_i(clear), .cnt_o(tec_o), .cnt_nxt_o(tec_nxt)
  );

  can_fc_err_cnt #(.W(REC_W), .INC(RX_INC)) u_rec (
    .clk_i(clk_i), .rst_ni(rst_ni), .err_i(rx_err_i), .ok_i(rx_ok_i),
    .freeze_i(bus_off), .clear_i(clear), .cnt_o(rec_o), .cnt_nxt_o(rec_nxt)
  );

  can_fc_state u_state (
    .clk_i(clk_i), .rst_ni(rst_ni), .tec_nxt_i(tec_nxt), .rec_nxt_i(rec_nxt),
    .recover_i(recover_i), .state_o(state), .bus_off_o(bus_off), .clear_o(clear)
  );

  assign state_o          = state;
  assign flag_recessive_o = (state != FC_ACTIVE);
  assign node_en_o        = !bus_off;
endmodule

// File: rtl/can_fc_checker.sv
module can_fc_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rx_err_i,
  input logic       tx_err_i,
  input logic       rx_ok_i,
  input logic       tx_ok_i,
  input logic       recover_i,
  input logic [8:0] tec_o,
  input logic [7:0] rec_o,
  input logic [1:0] state_o
);
  p_rx_inc_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_err_i && state_o != 2'd2) |=>
      rec_o == (($past(rec_o) == 8'hFF) ? 8'hFF : $past(rec_o) + 8'd1));

  p_tx_inc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_err_i && state_o != 2'd2) |=> tec_o == $past(tec_o) + 9'd8);

  p_rx_dec_floor_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_ok_i && !rx_err_i && state_o != 2'd2) |=>
      rec_o == (($past(rec_o) == 8'd0) ? 8'd0 : $past(rec_o) - 8'd1));

  p_tx_dec_floor_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_ok_i && !tx_err_i && state_o != 2'd2) |=>
      tec_o == (($past(tec_o) == 9'd0) ? 9'd0 : $past(tec_o) - 9'd1));

  p_active_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd0) |-> (tec_o <= 9'd127 && rec_o <= 8'd127));

  p_passive_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd1) |-> ((tec_o > 9'd127 || rec_o > 8'd127) && tec_o <= 9'd255));

  p_state_legal_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o != 2'd3);

  p_bus_off_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd2 && !recover_i) |=>
      ($stable(tec_o) && $stable(rec_o) && state_o == 2'd2));

  p_recover_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd2 && recover_i) |=>
      (tec_o == 9'd0 && rec_o == 8'd0 && state_o == 2'd0));
endmodule

bind can_fault_conf can_fc_checker u_fc_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .rx_err_i(rx_err_i), .tx_err_i(tx_err_i),
  .rx_ok_i(rx_ok_i), .tx_ok_i(tx_ok_i), .recover_i(recover_i),
  .tec_o(tec_o), .rec_o(rec_o), .state_o(state_o)
);

// File: tb/tb_can_fault_conf.sv
module tb_can_fault_conf;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx_err_i = 1'b0, tx_err_i = 1'b0, rx_ok_i = 1'b0, tx_ok_i = 1'b0, recover_i = 1'b0;
  logic [8:0] tec_o;
  logic [7:0] rec_o;
  logic [1:0] state_o;
  logic       flag_recessive_o, node_en_o;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk_i = ~clk_i;

  can_fault_conf dut (.*);

  // {rx_err, tx_err, rx_ok, tx_ok, recover, tec[8:0], rec[7:0], state[1:0]}
  localparam int NV = 11;
  localparam logic [23:0] VEC [NV] = '{
    {5'b10000, 9'd0,  8'd1, 2'd0},  // R1
    {5'b10100, 9'd0,  8'd2, 2'd0},  // R3 error wins
    {5'b00100, 9'd0,  8'd1, 2'd0},  // R3
    {5'b00100, 9'd0,  8'd0, 2'd0},  // R3
    {5'b00100, 9'd0,  8'd0, 2'd0},  // R3 floor
    {5'b01000, 9'd8,  8'd0, 2'd0},  // R2
    {5'b11000, 9'd16, 8'd1, 2'd0},  // R1 R2
    {5'b00110, 9'd15, 8'd0, 2'd0},  // R3
    {5'b01010, 9'd23, 8'd0, 2'd0},  // R3 error wins
    {5'b00001, 9'd23, 8'd0, 2'd0},  // R7 ignored outside bus off
    {5'b00010, 9'd22, 8'd0, 2'd0}   // R3
  };

  task automatic step(input logic [4:0] ev);
    @(negedge clk_i);
    {rx_err_i, tx_err_i, rx_ok_i, tx_ok_i, recover_i} = ev;
    @(negedge clk_i);
    {rx_err_i, tx_err_i, rx_ok_i, tx_ok_i, recover_i} = 5'b0;
  endtask

  task automatic check(input string req, input logic [8:0] et, input logic [7:0] er,
                       input logic [1:0] es);
    n_chk++;
    if (tec_o !== et || rec_o !== er || state_o !== es) begin
      n_err++;
      $display("FAIL %s: tec=%0d rec=%0d state=%0d expected tec=%0d rec=%0d state=%0d",
               req, tec_o, rec_o, state_o, et, er, es);
    end
  endtask

  task automatic check_out(input string req, input logic ef, input logic ee);
    n_chk++;
    if (flag_recessive_o !== ef || node_en_o !== ee) begin
      n_err++;
      $display("FAIL %s: flag=%0b en=%0b expected flag=%0b en=%0b",
               req, flag_recessive_o, node_en_o, ef, ee);
    end
  endtask

  initial begin
    #(20 * 200000);
    n_err++;
    $display("FAIL watchdog: run=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R8", 9'd0, 8'd0, 2'd0);
    check_out("R8 R5", 1'b0, 1'b1);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][23:19]);
      check($sformatf("vec%0d", i), VEC[i][18:10], VEC[i][9:2], VEC[i][1:0]);
    end

    // R2 R4: 22 -> 126 still active, 134 passive
    for (int i = 0; i < 13; i++) step(5'b01000);
    check("R4 below", 9'd126, 8'd0, 2'd0);
    step(5'b01000);
    check("R4 passive", 9'd134, 8'd0, 2'd1);
    check_out("R5 passive", 1'b1, 1'b1);
    for (int i = 0; i < 7; i++) step(5'b00010);
    check("R4 back active", 9'd127, 8'd0, 2'd0);
    check_out("R5 active", 1'b0, 1'b1);

    // R4: 127 -> 255 passive -> 263 bus off
    for (int i = 0; i < 16; i++) step(5'b01000);
    check("R4 edge", 9'd255, 8'd0, 2'd1);
    step(5'b00001);
    check("R7 passive ignore", 9'd255, 8'd0, 2'd1);
    step(5'b01000);
    check("R4 bus off", 9'd263, 8'd0, 2'd2);
    check_out("R5 bus off", 1'b1, 1'b0);

    // R6
    step(5'b10000);
    check("R6 rx_err", 9'd263, 8'd0, 2'd2);
    step(5'b00010);
    check("R6 tx_ok", 9'd263, 8'd0, 2'd2);
    step(5'b01100);
    check("R6 tx_err", 9'd263, 8'd0, 2'd2);

    // R7
    step(5'b00001);
    check("R7 recover", 9'd0, 8'd0, 2'd0);
    check_out("R7 enable", 1'b0, 1'b1);

    // R1 R4: receive counter to passive, then saturation
    for (int i = 0; i < 127; i++) step(5'b10000);
    check("R4 rec 127", 9'd0, 8'd127, 2'd0);
    step(5'b10000);
    check("R4 rec passive", 9'd0, 8'd128, 2'd1);
    for (int i = 0; i < 140; i++) step(5'b10000);
    check("R1 saturate", 9'd0, 8'd255, 2'd1);
    step(5'b00100);
    check("R3 rec dec", 9'd0, 8'd254, 2'd1);

    // R8 mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R8 mid", 9'd0, 8'd0, 2'd0);
    rst_ni = 1'b1;

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule